// File: doc/BRIEF.md
# Block-transfer address sequencer

This block sits between the decoder and the load/store unit of a small 32-bit core. It takes one decoded multi-register transfer and turns it into a stream of memory beats, one per clock. Each beat carries the register number and the word address for one access. The decoder supplies the following at a start strobe:

- the load or store direction;
- the stepping mode, either upward with the address advanced after each access, or downward;
- a writeback request;
- the base register number and the base register's value;
- a 16-bit register mask;
- two context bits saying whether the transfer is conditional inside an if-then group, and whether it is the final instruction of that group.

Before any beat is issued, the block checks the request against the architectural rules for such transfers. An illegal request produces a single fault pulse and no beats. A legal request walks the mask:

- upward mode goes from the lowest register to the highest, with addresses rising from the base;
- downward mode goes from the highest register to the lowest, with addresses falling from the base.

After the final beat the block presents the updated base value with a one-cycle strobe.

When a load reaches the program counter, the block samples the word returned for that beat. It then either announces a branch to that word with bit 0 cleared, or raises the fault if bit 0 is clear. The block owns no flags and never reports or changes any.

Top module: `blkxfer_seq`

## Requirements
- R1: An illegal request presented with `start` while idle produces `fault` high for exactly the next cycle and no beat at all (`beat_vld` stays low).
- R2: In upward mode (`down`=0), beat k (k counted from 0) is valid in the k-th cycle after the start edge. It carries the k-th lowest set bit of `reg_mask` and address `base_val + 4*k`.
- R3: In downward mode (`down`=1), beat k carries the k-th highest set bit of `reg_mask` and address `base_val - 4*k`.
- R4: A legal request with n bits set yields exactly n consecutive beats. `beat_last` is high on the final beat only, and the cycle after the final beat has `beat_vld` low.
- R5: With `wback`=1, `wb_vld` is high for one cycle, the cycle after the final beat. In that cycle `wb_reg` equals `base_reg`, and `wb_val` is `base_val + 4*n` in upward mode or `base_val - 4*(n-1)` in downward mode. With `wback`=0, `wb_vld` stays low.
- R6: `start` is ignored while beats are being issued: the running sequence, its beats and its result are unchanged.
- R7: The request is illegal when `base_reg` is 15, when bit 13 of `reg_mask` is set, or when `reg_mask` is zero.
- R8: A store (`is_load`=0) is illegal when bit 15 of `reg_mask` is set. A load is illegal when bits 15 and 14 are both set.
- R9: The request is illegal when `wback`=1 and the bit of `reg_mask` indexed by `base_reg` is set.
- R10: On a load beat for register 15, `pc_rdata` is sampled at the end of that beat. In the next cycle, if its bit 0 is 1, `br_vld` pulses with `br_target` equal to `pc_rdata` with bit 0 cleared. If its bit 0 is 0, `fault` pulses instead and `br_vld` stays low.
- R11: A load with bit 15 set and `in_cond_blk`=1 is illegal unless `cond_last`=1.
- R12: During and right after reset, `beat_vld`, `beat_last`, `wb_vld`, `fault` and `br_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| is_load | input | 1 | 1 = load transfer, 0 = store transfer |
| down | input | 1 | 1 = downward stepping, 0 = upward stepping |
| wback | input | 1 | Base update requested |
| base_reg | input | 4 | Base register number |
| base_val | input | 32 | Base register value |
| reg_mask | input | 16 | Registers to transfer, bit i = register i |
| in_cond_blk | input | 1 | Transfer is conditional within an if-then group |
| cond_last | input | 1 | Transfer is the final instruction of that group |
| pc_rdata | input | 32 | Word returned for a load beat of register 15 |
| beat_vld | output | 1 | Beat valid |
| beat_last | output | 1 | Final beat of the transfer |
| beat_reg | output | 4 | Register number of the beat |
| beat_addr | output | 32 | Word address of the beat |
| wb_vld | output | 1 | Base update strobe |
| wb_reg | output | 4 | Register to update |
| wb_val | output | 32 | New base value |
| fault | output | 1 | Illegal request or bad branch target, one-cycle pulse |
| br_vld | output | 1 | Branch strobe from a program-counter load |
| br_target | output | 32 | Branch destination, bit 0 clear |

## Verification
Counting clock edges from the one that samples `start`, the results fall due as follows:

- a legality fault is due in cycle 0;
- beat k is due in cycle k;
- the base update is due in cycle n;
- the branch or target fault is due one cycle after the beat for register 15. That is cycle n in upward mode and cycle 1 in downward mode, where it overlaps the second beat or the base update.

The bench drives every input on a falling edge and reads every output on the next falling edge, one cycle after another. Each read compares all outputs against values due in that exact cycle, so a result that arrives a cycle early or late fails as a mismatch and is not missed. For the ignored-start case, the bench raises `start` with an illegal mask during the beats. It drops `start` before the first edge at which the block is idle again, so the only visible effect could be on the running sequence.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    localparam int NREG  = 16;
    localparam int IDX_W = $clog2(NREG);
    localparam int CNT_W = IDX_W + 1;

    typedef logic [NREG-1:0]  rmask_t;
    typedef logic [IDX_W-1:0] ridx_t;
    typedef logic [CNT_W-1:0] rcnt_t;

    localparam ridx_t IDX_PC = ridx_t'(15);
    localparam ridx_t IDX_LR = ridx_t'(14);
    localparam ridx_t IDX_SP = ridx_t'(13);

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic  load;
        logic  down;
        logic  wback;
        ridx_t base;
    } xfer_ctl_t;

    function automatic rcnt_t count_regs(input rmask_t m);
        rcnt_t c;
        c = '0;
        for (int i = 0; i < NREG; i++) begin
            c = c + rcnt_t'(m[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/blkxfer_legal.sv
module blkxfer_legal
    import blkxfer_pkg::*;
(
    input  xfer_ctl_t ctl,
    input  rmask_t    mask,
    input  logic      in_cond,
    input  logic      cond_last,
    output logic      illegal
);
    logic base_is_pc;
    logic has_sp;
    logic has_pc;
    logic has_lr;
    logic empty;
    logic store_pc;
    logic load_pc_lr;
    logic wb_overlap;
    logic cond_pc;

    always_comb begin
        base_is_pc = (ctl.base == IDX_PC);
        has_sp     = mask[IDX_SP];
        has_pc     = mask[IDX_PC];
        has_lr     = mask[IDX_LR];
        empty      = (mask == '0);
        store_pc   = !ctl.load && has_pc;
        load_pc_lr = ctl.load && has_pc && has_lr;
        wb_overlap = ctl.wback && mask[ctl.base];
        cond_pc    = ctl.load && has_pc && in_cond && !cond_last;
        illegal    = base_is_pc || has_sp || empty || store_pc ||
                     load_pc_lr || wb_overlap || cond_pc;
    end

endmodule

// File: rtl/blkxfer_pick.sv
module blkxfer_pick
    import blkxfer_pkg::*;
(
    input  rmask_t pend,
    input  logic   down,
    output ridx_t  idx,
    output rmask_t hit,
    output logic   final_one
);
    rmask_t pend_rev;
    rmask_t src;
    rmask_t low;
    rmask_t low_rev;

    // Mirror the mask so one lowest-bit isolator serves both directions.
    for (genvar g = 0; g < NREG; g++) begin : g_rev
        assign pend_rev[g] = pend[NREG-1-g];
        assign low_rev[g]  = low[NREG-1-g];
    end

    always_comb begin
        src = down ? pend_rev : pend;
        low = src & (~src + rmask_t'(1));
        hit = down ? low_rev : low;
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                idx = ridx_t'(i);
            end
        end
        final_one = ((pend & ~hit) == '0);
    end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_load,
    input  logic              down,
    input  logic              wback,
    input  logic [IDX_W-1:0]  base_reg,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [NREG-1:0]   reg_mask,
    input  logic              in_cond_blk,
    input  logic              cond_last,
    input  logic [ADDR_W-1:0] pc_rdata,
    output logic              beat_vld,
    output logic              beat_last,
    output logic [IDX_W-1:0]  beat_reg,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              wb_vld,
    output logic [IDX_W-1:0]  wb_reg,
    output logic [ADDR_W-1:0] wb_val,
    output logic              fault,
    output logic              br_vld,
    output logic [ADDR_W-1:0] br_target
);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

    seq_state_e        state_q;
    xfer_ctl_t         ctl_q;
    xfer_ctl_t         ctl_in;
    rmask_t            pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wbval_q;
    logic [ADDR_W-1:0] wb_next;
    logic [ADDR_W-1:0] nregs_a;
    logic              wb_vld_q;
    logic              fault_q;
    logic              br_q;
    logic [ADDR_W-1:0] brt_q;
    logic              illegal;
    ridx_t             cur_idx;
    rmask_t            cur_hit;
    logic              cur_final;
    logic              running;
    logic              pc_beat;

    assign ctl_in = '{load: is_load, down: down, wback: wback, base: base_reg};

    blkxfer_legal u_legal (
        .ctl       (ctl_in),
        .mask      (reg_mask),
        .in_cond   (in_cond_blk),
        .cond_last (cond_last),
        .illegal   (illegal)
    );

    blkxfer_pick u_pick (
        .pend      (pend_q),
        .down      (ctl_q.down),
        .idx       (cur_idx),
        .hit       (cur_hit),
        .final_one (cur_final)
    );

    // Updated base: upward ends one word past the top, downward stays on the lowest word.
    always_comb begin
        nregs_a = ADDR_W'(count_regs(reg_mask));
        if (down) begin
            wb_next = base_val - STEP_A * (nregs_a - ADDR_W'(1));
        end else begin
            wb_next = base_val + STEP_A * nregs_a;
        end
    end

    assign running = (state_q == ST_RUN);
    assign pc_beat = running && ctl_q.load && (cur_idx == IDX_PC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ctl_q    <= '0;
            pend_q   <= '0;
            addr_q   <= '0;
            wbval_q  <= '0;
            wb_vld_q <= 1'b0;
            fault_q  <= 1'b0;
            br_q     <= 1'b0;
            brt_q    <= '0;
        end else begin
            wb_vld_q <= 1'b0;
            fault_q  <= 1'b0;
            br_q     <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (illegal) begin
                            fault_q <= 1'b1;
                        end else begin
                            state_q <= ST_RUN;
                            ctl_q   <= ctl_in;
                            pend_q  <= reg_mask;
                            addr_q  <= base_val;
                            wbval_q <= wb_next;
                        end
                    end
                end
                ST_RUN: begin
                    pend_q <= pend_q & ~cur_hit;
                    addr_q <= ctl_q.down ? (addr_q - STEP_A) : (addr_q + STEP_A);
                    if (pc_beat) begin
                        if (pc_rdata[0]) begin
                            br_q  <= 1'b1;
                            brt_q <= {pc_rdata[ADDR_W-1:1], 1'b0};
                        end else begin
                            fault_q <= 1'b1;
                        end
                    end
                    if (cur_final) begin
                        state_q  <= ST_IDLE;
                        wb_vld_q <= ctl_q.wback;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign beat_vld  = running;
    assign beat_last = running && cur_final;
    assign beat_reg  = running ? cur_idx : '0;
    assign beat_addr = addr_q;
    assign wb_vld    = wb_vld_q;
    assign wb_reg    = ctl_q.base;
    assign wb_val    = wbval_q;
    assign fault     = fault_q;
    assign br_vld    = br_q;
    assign br_target = brt_q;

endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              beat_vld,
    input logic              beat_last,
    input logic [IDX_W-1:0]  beat_reg,
    input logic [ADDR_W-1:0] beat_addr,
    input logic              wb_vld,
    input logic              fault,
    input logic              br_vld,
    input logic [ADDR_W-1:0] br_target
);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);
    localparam logic [IDX_W-1:0]  PC_IDX = {IDX_W{1'b1}};

    // R1: a fault not preceded by a beat comes from the legality check and issues no beat
    assert_fault_no_beat_R1: assert property (@(posedge clk) disable iff (rst)
        (fault && !$past(beat_vld)) |-> !beat_vld);

    // R2 and R3: consecutive beats move one word, registers in the same direction
    assert_beat_step_R2: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && $past(beat_vld) && !$past(beat_last)) |->
        ((beat_addr == $past(beat_addr) + STEP_A && beat_reg > $past(beat_reg)) ||
         (beat_addr == $past(beat_addr) - STEP_A && beat_reg < $past(beat_reg))));

    // R4: the final beat is followed by an idle cycle
    assert_last_then_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && beat_last) |=> !beat_vld);

    // R5: base update appears only right after a final beat
    assert_wb_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        wb_vld |-> ($past(beat_vld) && $past(beat_last)));

    // R10: a branch follows a program-counter beat, is even, and excludes a fault
    assert_branch_source_R10: assert property (@(posedge clk) disable iff (rst)
        br_vld |-> (!fault && !br_target[0] && $past(beat_vld) && $past(beat_reg) == PC_IDX));

    // R12: last flag never without a valid beat
    assert_last_has_beat_R12: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_vld);

endmodule

bind blkxfer_seq blkxfer_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (blkxfer_pkg::IDX_W),
    .STEP   (STEP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .beat_vld  (beat_vld),
    .beat_last (beat_last),
    .beat_reg  (beat_reg),
    .beat_addr (beat_addr),
    .wb_vld    (wb_vld),
    .fault     (fault),
    .br_vld    (br_vld),
    .br_target (br_target)
);

// File: tb/sim_blkxfer_seq.sv
`timescale 1ns/1ps
module sim_blkxfer_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_load = 1'b0;
    logic        down = 1'b0;
    logic        wback = 1'b0;
    logic [3:0]  base_reg = '0;
    logic [31:0] base_val = '0;
    logic [15:0] reg_mask = '0;
    logic        in_cond_blk = 1'b0;
    logic        cond_last = 1'b0;
    logic [31:0] pc_rdata = '0;
    logic        beat_vld, beat_last, wb_vld, fault, br_vld;
    logic [3:0]  beat_reg, wb_reg;
    logic [31:0] beat_addr, wb_val, br_target;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    blkxfer_seq u0 (
        .clk(clk), .rst(rst), .start(start), .is_load(is_load), .down(down),
        .wback(wback), .base_reg(base_reg), .base_val(base_val), .reg_mask(reg_mask),
        .in_cond_blk(in_cond_blk), .cond_last(cond_last), .pc_rdata(pc_rdata),
        .beat_vld(beat_vld), .beat_last(beat_last), .beat_reg(beat_reg),
        .beat_addr(beat_addr), .wb_vld(wb_vld), .wb_reg(wb_reg), .wb_val(wb_val),
        .fault(fault), .br_vld(br_vld), .br_target(br_target)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic run(input bit ld, input bit dn, input bit wb, input logic [3:0] bi,
                       input logic [31:0] bv, input logic [15:0] m, input bit ci,
                       input bit cl, input logic [31:0] pcw, input bit poke);
        int ord[16];
        int n;
        int pidx;
        string ftag;
        string otag;
        bit bad;
        logic [31:0] exp_wb;
        n = 0;
        pidx = -1;
        for (int i = 0; i < 16; i++) begin
            int r;
            r = dn ? 15 - i : i;
            if (m[r]) begin
                ord[n] = r;
                if (r == 15 && ld) pidx = n;
                n++;
            end
        end
        bad = 1'b0;
        ftag = "R1";
        if (bi == 4'd15 || m[13] || m == 16'h0) begin bad = 1'b1; ftag = "R7"; end
        else if ((!ld && m[15]) || (ld && m[15] && m[14])) begin bad = 1'b1; ftag = "R8"; end
        else if (wb && m[bi]) begin bad = 1'b1; ftag = "R9"; end
        else if (ld && m[15] && ci && !cl) begin bad = 1'b1; ftag = "R11"; end
        otag = dn ? "R3" : "R2";
        exp_wb = dn ? bv - 32'(4 * (n - 1)) : bv + 32'(4 * n);

        @(negedge clk);
        is_load = ld; down = dn; wback = wb; base_reg = bi; base_val = bv;
        reg_mask = m; in_cond_blk = ci; cond_last = cl; pc_rdata = pcw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            chk(ftag, "fault pulse", 32'(fault), 32'd1);
            chk("R1", "no beat on illegal", 32'(beat_vld), 32'd0);
            @(negedge clk);
            chk("R1", "fault one cycle", 32'(fault), 32'd0);
            chk("R1", "still no beat", 32'(beat_vld), 32'd0);
            return;
        end
        for (int k = 0; k <= n; k++) begin
            bit eb;
            bit ef;
            eb = (pidx >= 0) && (k == pidx + 1) && pcw[0];
            ef = (pidx >= 0) && (k == pidx + 1) && !pcw[0];
            if (k < n) begin
                chk(poke ? "R6" : otag, "beat valid", 32'(beat_vld), 32'd1);
                chk(otag, "beat reg", 32'(beat_reg), 32'(ord[k]));
                chk(otag, "beat addr", beat_addr, dn ? bv - 32'(4 * k) : bv + 32'(4 * k));
                chk("R4", "last flag", 32'(beat_last), 32'(k == n - 1));
                chk("R5", "no early wb", 32'(wb_vld), 32'd0);
            end else begin
                chk("R4", "idle after last", 32'(beat_vld), 32'd0);
                chk("R5", "wb strobe", 32'(wb_vld), 32'(wb));
                if (wb) begin
                    chk("R5", "wb value", wb_val, exp_wb);
                    chk("R5", "wb reg", 32'(wb_reg), 32'(bi));
                end
            end
            chk(poke ? "R6" : "R10", "fault", 32'(fault), 32'(ef));
            chk("R10", "branch strobe", 32'(br_vld), 32'(eb));
            if (eb) chk("R10", "branch target", br_target, pcw & 32'hFFFF_FFFE);
            if (poke && k < n - 1) begin
                start = 1'b1;
                reg_mask = 16'h2001;
                base_val = ~bv;
            end else begin
                start = 1'b0;
            end
            if (k < n) @(negedge clk);
        end
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "reset beat_vld", 32'(beat_vld), 32'd0);
        chk("R12", "reset wb_vld", 32'(wb_vld), 32'd0);
        chk("R12", "reset fault", 32'(fault), 32'd0);
        chk("R12", "reset br_vld", 32'(br_vld), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "post reset beat_last", 32'(beat_last), 32'd0);

        // single-register sweep, every direction and kind
        for (int i = 0; i < 16; i++) begin
            for (int v = 0; v < 8; v++) begin
                logic [3:0] b;
                b = 4'((i + 3) % 15);
                run(v[0], v[1], v[2], b, 32'h2000_0100 + 32'(i * 64),
                    16'(1) << i, 1'b0, 1'b0, 32'h0000_8001 + 32'(v[0] ? 0 : 1), 1'b0);
            end
        end

        // pseudo-random sweep
        for (int t = 0; t < 700; t++) begin
            logic [15:0] m;
            lfsr = next_rand(lfsr);
            m = lfsr[15:0];
            if (!lfsr[16]) m[13] = 1'b0;
            if (lfsr[17]) m[14] = 1'b0;
            run(lfsr[18], lfsr[19], lfsr[20], lfsr[24:21], next_rand(lfsr) & 32'hFFFF_FFFC,
                m, lfsr[25], lfsr[26], {lfsr[31:27], 26'h0, lfsr[29]}, 1'b0);
        end

        // directed legality corners
        run(1'b1, 1'b0, 1'b0, 4'd2, 32'h100, 16'h0000, 1'b0, 1'b0, 32'h1, 1'b0); // R7 empty
        run(1'b1, 1'b0, 1'b0, 4'd15, 32'h100, 16'h0003, 1'b0, 1'b0, 32'h1, 1'b0); // R7 base PC
        run(1'b0, 1'b1, 1'b0, 4'd1, 32'h100, 16'h2004, 1'b0, 1'b0, 32'h1, 1'b0); // R7 SP
        run(1'b0, 1'b0, 1'b0, 4'd1, 32'h100, 16'h8004, 1'b0, 1'b0, 32'h1, 1'b0); // R8 store PC
        run(1'b1, 1'b0, 1'b0, 4'd1, 32'h100, 16'hC004, 1'b0, 1'b0, 32'h1, 1'b0); // R8 PC+LR
        run(1'b1, 1'b0, 1'b0, 4'd1, 32'h100, 16'h4004, 1'b0, 1'b0, 32'h1, 1'b0); // R8 LR only legal
        run(1'b1, 1'b0, 1'b1, 4'd2, 32'h100, 16'h0014, 1'b0, 1'b0, 32'h1, 1'b0); // R9
        run(1'b1, 1'b0, 1'b0, 4'd2, 32'h100, 16'h0014, 1'b0, 1'b0, 32'h1, 1'b0); // R9 no wb legal
        run(1'b1, 1'b1, 1'b0, 4'd0, 32'h400, 16'h8006, 1'b1, 1'b0, 32'h81, 1'b0); // R11
        run(1'b1, 1'b1, 1'b1, 4'd0, 32'h400, 16'h8006, 1'b1, 1'b1, 32'h81, 1'b0); // R11 last ok, R10
        run(1'b1, 1'b0, 1'b1, 4'd0, 32'h400, 16'h8006, 1'b0, 1'b0, 32'h80, 1'b0); // R10 bad target
        run(1'b1, 1'b1, 1'b0, 4'd3, 32'h400, 16'h8000, 1'b0, 1'b0, 32'h80, 1'b0); // R10 single PC

        // R6 start during a run is ignored
        run(1'b0, 1'b0, 1'b1, 4'd0, 32'h1000, 16'h1F7E, 1'b0, 1'b0, 32'h0, 1'b1);
        run(1'b0, 1'b1, 1'b1, 4'd15 - 4'd1, 32'h1000, 16'h0F0F, 1'b0, 1'b0, 32'h0, 1'b1);
        run(1'b1, 1'b1, 1'b0, 4'd0, 32'hFFFF_FFF0, 16'h5FFE, 1'b0, 1'b0, 32'h0, 1'b1);

        @(negedge clk);
        chk("R6", "no late start", 32'(beat_vld), 32'd0);
        chk("R6", "no late fault", 32'(fault), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule